// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home node of a directory-based coherence scheme. For every memory block it owns, it keeps a directory entry made of a sharing state and a bit vector with one bit per processor node. Remote caches send it three kinds of request: a read miss, a write miss, or a write-back of a dirty block. Each request carries the requesting node's ID and the block address. The controller answers with point-to-point messages. It sends a data reply to the requester, invalidates to the nodes recorded as sharers, and a fetch or fetch-and-invalidate to a recorded owner. It never broadcasts.

The controller serves one request at a time. It stays busy while it sends invalidates, one per cycle, and while it waits for an owner to return its dirty block. During those cycles it refuses new work. A small memory array holds the block contents. Write-backs update this array, and data replies are read from it. The network and the caches sit outside the block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every block is uncached, every memory word reads zero, `msg_valid` is low and `req_ready` is high.
- R2: A read miss (request kind 0) to an uncached block produces a data reply (message kind 0) to the requester in the cycle after acceptance. The block becomes shared, with only the requester recorded.
- R3: A read miss to a shared block adds the requester to the sharers and produces only a data reply, with no invalidates.
- R4: A write miss (request kind 1) to a shared block sends one invalidate (message kind 1) per cycle to each recorded sharer except the requester, in ascending node ID, starting the cycle after acceptance. A data reply to the requester follows in the next cycle. The block then becomes exclusive, owned by the requester.
- R5: A write miss to an uncached block produces only a data reply, in the cycle after acceptance, and leaves the block exclusive to the requester.
- R6: A read miss to an exclusive block sends a fetch (message kind 2) to the owner and then waits for that owner's write-back (request kind 2) of the same block. The returned data is stored in memory and replied to the requester in the cycle after the write-back is accepted. The block becomes shared by the old owner and the requester.
- R7: A write miss to an exclusive block sends a fetch-and-invalidate (message kind 3) to the owner, waits for its write-back, stores and replies the returned data, and leaves the block exclusive to the requester.
- R8: A write-back from the owner of an exclusive block, received while idle, stores its data, makes the block uncached and emits no message.
- R9: A write-back from a node that is not the owner, or to a block that is not exclusive, is ignored. Memory contents and directory state stay unchanged.
- R10: `req_ready` is low while invalidates, a fetch or a reply are being issued. While the controller waits for a write-back, `req_ready` is high only for a write-back from the owner of the pending block.
- R11: An exclusive block always records exactly one node, an uncached block records none, and a shared block records at least one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The offered request is taken at this edge |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | $clog2(NODES) | Requesting node ID |
| req_addr | input | $clog2(BLOCKS) | Block address |
| req_data | input | DATA_W | Block data carried by a write-back |
| msg_valid | output | 1 | An outgoing message is present this cycle |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dest | output | $clog2(NODES) | Destination node ID |
| msg_addr | output | $clog2(BLOCKS) | Block address of the message |
| msg_data | output | DATA_W | Block data for a data reply, zero otherwise |

## Verification
A corrupted sharer vector stays hidden until the next write miss to that block. At that point it shows up as a missing, extra or misordered invalidate, within one cycle per recorded sharer. A wrong sharing state shows at the next request to the block. In that case the controller answers at once where a fetch was due, or it sends a fetch and stalls where a direct reply was due. Lost write-back data appears in the following data reply for the block. The bench therefore follows each state change with a request that reveals it, and it compares every message against an ordered list of expected messages.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SHR = 2'd1,
        DIR_EXC = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        REQ_RD = 2'd0,
        REQ_WR = 2'd1,
        REQ_WB = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MSG_DATA      = 2'd0,
        MSG_INV       = 2'd1,
        MSG_FETCH     = 2'd2,
        MSG_FETCH_INV = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        C_IDLE  = 3'd0,
        C_INVAL = 3'd1,
        C_FETCH = 3'd2,
        C_WAIT  = 3'd3,
        C_REPLY = 3'd4
    } ctrl_state_e;

endpackage

// File: rtl/dir_pick.sv
module dir_pick #(
    parameter int NODES = 4,
    localparam int IDW = $clog2(NODES)
) (
    input  logic [NODES-1:0] mask,
    output logic [IDW-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDW'(i);
        end
    end
endmodule

// File: rtl/dir_table.sv
module dir_table
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 32,
    localparam int AW = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    output dir_state_e        rd_state,
    output logic [NODES-1:0]  rd_sharers,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dir_we,
    input  dir_state_e        dir_wstate,
    input  logic [NODES-1:0]  dir_wsharers,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_wdata
);
    dir_state_e        st_q  [BLOCKS];
    logic [NODES-1:0]  sh_q  [BLOCKS];
    logic [DATA_W-1:0] mem_q [BLOCKS];

    assign rd_state   = st_q[addr];
    assign rd_sharers = sh_q[addr];
    assign rd_data    = mem_q[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BLOCKS; i++) begin
                st_q[i]  <= DIR_UNC;
                sh_q[i]  <= '0;
                mem_q[i] <= '0;
            end
        end else begin
            if (dir_we) begin
                st_q[addr] <= dir_wstate;
                sh_q[addr] <= dir_wsharers;
            end
            if (mem_we) mem_q[addr] <= mem_wdata;
        end
    end

    for (genvar g = 0; g < BLOCKS; g++) begin : g_chk
        a_r11_excl_single: assert property (@(posedge clk) disable iff (rst)
            (st_q[g] == DIR_EXC) |-> ($countones(sh_q[g]) == 1));
        a_r11_unc_empty: assert property (@(posedge clk) disable iff (rst)
            (st_q[g] == DIR_UNC) |-> (sh_q[g] == '0));
        a_r11_shr_nonempty: assert property (@(posedge clk) disable iff (rst)
            (st_q[g] == DIR_SHR) |-> (sh_q[g] != '0));
    end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 32,
    localparam int IDW = $clog2(NODES),
    localparam int AW  = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [IDW-1:0]    req_src,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              msg_valid,
    output logic [1:0]        msg_kind,
    output logic [IDW-1:0]    msg_dest,
    output logic [AW-1:0]     msg_addr,
    output logic [DATA_W-1:0] msg_data
);
    localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

    ctrl_state_e      state_q, state_d;
    req_kind_e        pkind_q, pkind_d;
    logic [IDW-1:0]   psrc_q, psrc_d;
    logic [AW-1:0]    paddr_q, paddr_d;
    logic [IDW-1:0]   owner_q, owner_d;
    logic [NODES-1:0] inv_q, inv_d;

    logic [AW-1:0]     tbl_addr;
    dir_state_e        rd_state;
    logic [NODES-1:0]  rd_sharers;
    logic [DATA_W-1:0] rd_data;
    logic              dir_we, mem_we;
    dir_state_e        dir_wstate;
    logic [NODES-1:0]  dir_wsharers;
    logic [DATA_W-1:0] mem_wdata;

    logic [IDW-1:0]   own_idx, inv_idx;
    logic [NODES-1:0] others;
    logic [NODES-1:0] inv_left;
    req_kind_e        in_kind;
    logic             wb_match;

    assign in_kind  = req_kind_e'(req_kind);
    assign tbl_addr = (state_q == C_IDLE) ? req_addr : paddr_q;
    assign others   = rd_sharers & ~(ONE << req_src);
    assign inv_left = inv_q & ~(ONE << inv_idx);
    assign wb_match = req_valid && (in_kind == REQ_WB)
                   && (req_src == owner_q) && (req_addr == paddr_q);
    assign msg_addr = paddr_q;

    dir_table #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_table (
        .clk(clk), .rst(rst), .addr(tbl_addr),
        .rd_state(rd_state), .rd_sharers(rd_sharers), .rd_data(rd_data),
        .dir_we(dir_we), .dir_wstate(dir_wstate), .dir_wsharers(dir_wsharers),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    dir_pick #(.NODES(NODES)) u_owner (.mask(rd_sharers), .idx(own_idx));
    dir_pick #(.NODES(NODES)) u_inv   (.mask(inv_q),      .idx(inv_idx));

    always_comb begin
        state_d      = state_q;
        pkind_d      = pkind_q;
        psrc_d       = psrc_q;
        paddr_d      = paddr_q;
        owner_d      = owner_q;
        inv_d        = inv_q;
        req_ready    = 1'b0;
        dir_we       = 1'b0;
        dir_wstate   = DIR_UNC;
        dir_wsharers = '0;
        mem_we       = 1'b0;
        mem_wdata    = req_data;
        msg_valid    = 1'b0;
        msg_kind     = MSG_DATA;
        msg_dest     = psrc_q;
        msg_data     = '0;
        unique case (state_q)
            C_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    pkind_d = in_kind;
                    psrc_d  = req_src;
                    paddr_d = req_addr;
                    owner_d = own_idx;
                    case (in_kind)
                        REQ_RD: state_d = (rd_state == DIR_EXC) ? C_FETCH : C_REPLY;
                        REQ_WR: begin
                            if (rd_state == DIR_EXC) begin
                                state_d = C_FETCH;
                            end else if (rd_state == DIR_SHR && others != '0) begin
                                inv_d   = others;
                                state_d = C_INVAL;
                            end else begin
                                state_d = C_REPLY;
                            end
                        end
                        REQ_WB: begin
                            if (rd_state == DIR_EXC && rd_sharers[req_src]) begin
                                mem_we = 1'b1;
                                dir_we = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            C_INVAL: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_INV;
                msg_dest  = inv_idx;
                inv_d     = inv_left;
                if (inv_left == '0) state_d = C_REPLY;
            end
            C_FETCH: begin
                msg_valid = 1'b1;
                msg_kind  = (pkind_q == REQ_RD) ? MSG_FETCH : MSG_FETCH_INV;
                msg_dest  = owner_q;
                state_d   = C_WAIT;
            end
            C_WAIT: begin
                req_ready = wb_match;
                if (wb_match) begin
                    mem_we  = 1'b1;
                    state_d = C_REPLY;
                end
            end
            C_REPLY: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_DATA;
                msg_dest  = psrc_q;
                msg_data  = rd_data;
                dir_we    = 1'b1;
                if (pkind_q == REQ_RD) begin
                    dir_wstate   = DIR_SHR;
                    dir_wsharers = rd_sharers | (ONE << psrc_q);
                end else begin
                    dir_wstate   = DIR_EXC;
                    dir_wsharers = ONE << psrc_q;
                end
                state_d = C_IDLE;
            end
            default: state_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= C_IDLE;
            pkind_q <= REQ_RD;
            psrc_q  <= '0;
            paddr_q <= '0;
            owner_q <= '0;
            inv_q   <= '0;
        end else begin
            state_q <= state_d;
            pkind_q <= pkind_d;
            psrc_q  <= psrc_d;
            paddr_q <= paddr_d;
            owner_q <= owner_d;
            inv_q   <= inv_d;
        end
    end

    a_r2_direct_reply: assert property (@(posedge clk) disable iff (rst)
        (state_q == C_IDLE && req_valid && in_kind == REQ_RD && rd_state == DIR_UNC)
        |=> (msg_valid && msg_kind == MSG_DATA && msg_dest == $past(req_src)));

    a_r4_inv_not_requester: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MSG_INV) |-> (msg_dest != psrc_q));

    a_r4_inv_ascending: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MSG_INV && $past(msg_valid && msg_kind == MSG_INV))
        |-> (msg_dest > $past(msg_dest)));

    a_r6_wb_then_reply: assert property (@(posedge clk) disable iff (rst)
        (state_q == C_WAIT && req_valid && req_ready)
        |=> (msg_valid && msg_kind == MSG_DATA && msg_data == $past(req_data)));

    a_r8_wb_silent: assert property (@(posedge clk) disable iff (rst)
        (state_q == C_IDLE && req_valid && in_kind == REQ_WB) |=> !msg_valid);

    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {C_INVAL, C_FETCH, C_REPLY}) |-> !req_ready);
endmodule

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
    localparam int NODES = 4, BLOCKS = 16, DATA_W = 32;

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  dest;
        logic [3:0]  addr;
        logic [31:0] data;
    } exp_t;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_src = '0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_data = '0;
    logic        msg_valid;
    logic [1:0]  msg_kind, msg_dest;
    logic [3:0]  msg_addr;
    logic [31:0] msg_data;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    exp_t  q[$];
    string tq[$];
    exp_t  e;
    string t;

    always #10 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) i_dir_home_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic expect_msg(input logic [1:0] k, input logic [1:0] d,
                              input logic [3:0] a, input logic [31:0] v, input string tag);
        q.push_back('{kind: k, dest: d, addr: a, data: v});
        tq.push_back(tag);
    endtask

    task automatic send(input logic [1:0] k, input logic [1:0] s,
                        input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_src = s; req_addr = a; req_data = v;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && msg_valid) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL unexpected message actual=kind%0d/dest%0d expected=none",
                         msg_kind, msg_dest);
            end else begin
                e = q.pop_front();
                t = tq.pop_front();
                if (msg_kind != e.kind || msg_dest != e.dest ||
                    msg_addr != e.addr || msg_data != e.data) begin
                    fails++;
                    $display("FAIL %s actual=k%0d d%0d a%0d v%h expected=k%0d d%0d a%0d v%h",
                             t, msg_kind, msg_dest, msg_addr, msg_data,
                             e.kind, e.dest, e.addr, e.data);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(msg_valid == 1'b0, "R1 no message after reset", int'(msg_valid), 0);

        // R1 R2: first read of block 3 returns zero at once
        expect_msg(2'd0, 2'd1, 4'd3, 32'h0, "R1 R2 read uncached");
        send(2'd0, 2'd1, 4'd3, '0);
        chk(msg_valid && msg_kind == 2'd0, "R2 reply in cycle after accept", int'(msg_valid), 1);

        // R3: more readers join
        expect_msg(2'd0, 2'd2, 4'd3, 32'h0, "R3 read shared node2");
        send(2'd0, 2'd2, 4'd3, '0);
        expect_msg(2'd0, 2'd0, 4'd3, 32'h0, "R3 read shared node0");
        send(2'd0, 2'd0, 4'd3, '0);

        // R4: write miss by node1, sharers {0,1,2}
        expect_msg(2'd1, 2'd0, 4'd3, 32'h0, "R4 inv node0");
        expect_msg(2'd1, 2'd2, 4'd3, 32'h0, "R4 inv node2");
        expect_msg(2'd0, 2'd1, 4'd3, 32'h0, "R4 reply after invs");
        send(2'd1, 2'd1, 4'd3, '0);
        chk(msg_valid && msg_kind == 2'd1 && msg_dest == 2'd0, "R4 first inv timing",
            int'(msg_kind), 1);
        repeat (2) @(negedge clk);

        // R6 R10: read by node3 of a block owned by node1
        expect_msg(2'd2, 2'd1, 4'd3, 32'h0, "R6 fetch to owner");
        expect_msg(2'd0, 2'd3, 4'd3, 32'hA5A5_0001, "R6 reply with written-back data");
        send(2'd0, 2'd3, 4'd3, '0);
        #1;
        chk(req_ready == 1'b0, "R10 not ready while fetching", int'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_src = 2'd2; req_addr = 4'd5;
        #1;
        chk(req_ready == 1'b0, "R10 other request refused while waiting", int'(req_ready), 0);
        req_kind = 2'd2; req_src = 2'd0; req_addr = 4'd3;
        #1;
        chk(req_ready == 1'b0, "R10 write-back from non-owner refused", int'(req_ready), 0);
        req_valid = 1'b0;
        send(2'd2, 2'd1, 4'd3, 32'hA5A5_0001);
        repeat (2) @(negedge clk);

        // R4 R6: sharers now {1,3}; write miss by node0
        expect_msg(2'd1, 2'd1, 4'd3, 32'h0, "R6 old owner kept as sharer");
        expect_msg(2'd1, 2'd3, 4'd3, 32'h0, "R4 inv node3");
        expect_msg(2'd0, 2'd0, 4'd3, 32'hA5A5_0001, "R4 reply keeps memory");
        send(2'd1, 2'd0, 4'd3, '0);
        repeat (3) @(negedge clk);

        // R7: write miss by node2 to block owned by node0
        expect_msg(2'd3, 2'd0, 4'd3, 32'h0, "R7 fetch-inv to owner");
        expect_msg(2'd0, 2'd2, 4'd3, 32'h0000_1234, "R7 reply with returned data");
        send(2'd1, 2'd2, 4'd3, '0);
        send(2'd2, 2'd0, 4'd3, 32'h0000_1234);
        repeat (2) @(negedge clk);

        // R9: write-back from non-owner is ignored; R8: owner's write-back
        send(2'd2, 2'd1, 4'd3, 32'hDEAD_BEEF);
        send(2'd2, 2'd2, 4'd3, 32'h5555_5555);
        // R5 R8: uncached now, write miss gives a bare reply with stored data
        expect_msg(2'd0, 2'd1, 4'd3, 32'h5555_5555, "R8 R5 uncached after write-back");
        send(2'd1, 2'd1, 4'd3, '0);
        chk(msg_valid && msg_kind == 2'd0, "R5 reply in cycle after accept", int'(msg_valid), 1);

        // R9: write-back to an uncached block is ignored
        send(2'd2, 2'd0, 4'd7, 32'hBEEF_0000);
        expect_msg(2'd0, 2'd0, 4'd7, 32'h0, "R9 memory untouched");
        send(2'd0, 2'd0, 4'd7, '0);

        // R4: requester is the only sharer, no invalidates
        expect_msg(2'd0, 2'd0, 4'd7, 32'h0, "R4 sole sharer upgrade");
        send(2'd1, 2'd0, 4'd7, '0);
        chk(msg_valid && msg_kind == 2'd0, "R4 no inv for requester", int'(msg_kind), 0);

        // R5 R11: write miss to uncached block 9, single owner revealed by fetch
        expect_msg(2'd0, 2'd2, 4'd9, 32'h0, "R5 write uncached");
        send(2'd1, 2'd2, 4'd9, '0);
        expect_msg(2'd2, 2'd2, 4'd9, 32'h0, "R5 R11 single owner fetched");
        expect_msg(2'd0, 2'd3, 4'd9, 32'h0000_0077, "R6 reply block9");
        send(2'd0, 2'd3, 4'd9, '0);
        send(2'd2, 2'd2, 4'd9, 32'h0000_0077);

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R4 R6 all expected messages seen", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule